// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a dynamic memory array alive without row addresses from the host. After reset it waits out the power-up pause, issues a burst of CAS-before-RAS refresh cycles on its own, and only then signals that host accesses may begin. From that point an interval timer adds one owed refresh per refresh slot. The block asks the access controller for the strobe bus and, once granted, drives RAS and CAS through the full CBR sequence itself.

Owed refreshes build up in a saturating counter while the bus is busy, so several can be postponed and later issued back to back under one grant. When the counter is full, the block raises an urgent flag, and the controller must serve that request before anything else. Write enable is held high through every cycle, so a CBR cycle can never turn into a test-mode entry. All strobe timings are given in nanoseconds and converted to clock cycles by rounding up.

Top module: `refr_sched`

## Requirements
- R1: While reset is high, ras_n, cas_n and we_n are 1, and bus_req, req_urgent, init_done and strobe_drive are 0.
- R2: After reset is released, no strobe is driven for the power-up pause; strobe_drive first rises between PAUSE_CYC and PAUSE_CYC+2 cycles after release.
- R3: After the pause, exactly INIT_CYCLES CBR cycles run back to back with bus_gnt ignored. bus_req stays 0 until init_done rises, and init_done rises after the closing precharge.
- R4: In every cycle, CAS falls while RAS is high, at least CSR_CYC cycles before RAS falls. CAS stays low for at least CHR_CYC cycles after RAS falls.
- R5: RAS stays low for at least RAS_CYC cycles. Before every CAS fall, RAS has been high for at least RP_CYC cycles.
- R6: we_n is 1 at every RAS falling edge (in fact at all times).
- R7: Once init_done is set, one refresh is owed every INTERVAL_CYC cycles. The first one makes bus_req rise exactly INTERVAL_CYC cycles after init_done rises, and bus_req stays high while any refresh is owed.
- R8: The owed count saturates at MAX_OWED, and further timer ticks are lost. A grant after k ticks yields exactly min(k, MAX_OWED) CBR cycles, after which bus_req falls.
- R9: req_urgent is 1 exactly when MAX_OWED refreshes are owed.
- R10: bus_gnt is sampled only when a cycle is about to start. If the grant is withdrawn mid-cycle, that cycle completes, no further cycle starts, and the remaining refreshes stay owed with bus_req held high.
- R11: strobe_drive is 1 whenever the block owns the strobes. While it is 0, ras_n and cas_n are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_gnt | input | 1 | Strobe bus granted by the access controller |
| bus_req | output | 1 | Refresh owed, requesting the strobe bus |
| req_urgent | output | 1 | Owed count at its limit, serve first |
| init_done | output | 1 | Power-up sequence complete, host access allowed |
| strobe_drive | output | 1 | Block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The hardest state to reach is a full owed counter with more timer ticks still arriving, because the slot timer runs freely and its phase is hidden. The bench locks onto that phase by waiting for bus_req to rise on a fresh tick. It then holds the grant off for a counted number of whole slots plus half a slot before granting, so the number of CBR cycles that follow shows the saturated count. A second sequence withdraws the grant right after the strobes are taken, to show that exactly one cycle completes and the rest remain owed.

// File: rtl/refr_pkg.sv
package refr_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_CSR,
    SQ_CHR,
    SQ_HOLD,
    SQ_TAIL
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refr_interval_timer.sv
module refr_interval_timer #(
  parameter int INTERVAL_CYC = 3125
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int LIM = (INTERVAL_CYC < 2) ? 2 : INTERVAL_CYC;
  localparam int CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(LIM - 1));
  assign tick = en && wrap;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/refr_owed_ctr.sv
module refr_owed_ctr #(
  parameter int MAX_OWED = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic                          fin,
  output logic [$clog2(MAX_OWED+1)-1:0] owed
);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [OW-1:0] owed_n;

  always_comb begin
    owed_n = owed;
    unique case ({tick, fin})
      2'b10:   if (owed != OW'(MAX_OWED)) owed_n = owed + 1'b1;
      2'b01:   if (owed != '0) owed_n = owed - 1'b1;
      default: owed_n = owed;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) owed <= '0;
    else     owed <= owed_n;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(owed) <= MAX_OWED); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    fin |-> (owed != '0)); // R8

endmodule

// File: rtl/refr_cbr_seq.sv
module refr_cbr_seq
  import refr_pkg::*;
#(
  parameter int RP_CYC   = 8,
  parameter int CSR_CYC  = 1,
  parameter int CHR_CYC  = 2,
  parameter int HOLD_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic ras_n,
  output logic cas_n,
  output logic drive,
  output logic fin
);
  localparam int MAXD = max_of(max_of(RP_CYC, CSR_CYC), max_of(CHR_CYC, HOLD_CYC));
  localparam int CW   = $clog2(MAXD + 1);

  seq_state_t    st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          last;

  assign last = (cnt == '0);
  assign fin  = (st == SQ_HOLD) && last;

  always_comb begin
    st_n  = st;
    cnt_n = last ? cnt : cnt - 1'b1;
    unique case (st)
      SQ_IDLE: begin
        cnt_n = cnt;
        if (go) begin
          st_n  = SQ_PRE;
          cnt_n = CW'(RP_CYC - 1);
        end
      end
      SQ_PRE: if (last) begin
        st_n  = SQ_CSR;
        cnt_n = CW'(CSR_CYC - 1);
      end
      SQ_CSR: if (last) begin
        st_n  = SQ_CHR;
        cnt_n = CW'(CHR_CYC - 1);
      end
      SQ_CHR: if (last) begin
        st_n  = SQ_HOLD;
        cnt_n = CW'(HOLD_CYC - 1);
      end
      SQ_HOLD: if (last) begin
        st_n  = go ? SQ_PRE : SQ_TAIL;
        cnt_n = CW'(RP_CYC - 1);
      end
      SQ_TAIL: if (last) st_n = SQ_IDLE;
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      drive <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      ras_n <= !((st_n == SQ_CHR) || (st_n == SQ_HOLD));
      cas_n <= !((st_n == SQ_CSR) || (st_n == SQ_CHR));
      drive <= (st_n != SQ_IDLE);
    end
  end

  AST_CAS_LEADS: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R4

  AST_CAS_RISE_IN_ROW: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> (!ras_n && $past(!ras_n))); // R4

endmodule

// File: rtl/refr_sched.sv
module refr_sched
  import refr_pkg::*;
#(
  parameter int CLK_NS       = 5,
  parameter bit LOW_POWER    = 1'b0,
  parameter int ROWS         = 2048,
  parameter int WINDOW_NS    = 32_000_000,
  parameter int WINDOW_LP_NS = 128_000_000,
  parameter int PAUSE_NS     = 200_000,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_OWED     = 8,
  parameter int T_RP_NS      = 40,
  parameter int T_RAS_NS     = 60,
  parameter int T_CSR_NS     = 5,
  parameter int T_CHR_NS     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_gnt,
  output logic bus_req,
  output logic req_urgent,
  output logic init_done,
  output logic strobe_drive,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int WIN_NS       = LOW_POWER ? WINDOW_LP_NS : WINDOW_NS;
  localparam int INTERVAL_CYC = max_of(2, WIN_NS / ROWS / CLK_NS);
  localparam int PAUSE_CYC    = ns_to_cyc(PAUSE_NS, CLK_NS);
  localparam int RP_CYC       = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int RAS_CYC      = ns_to_cyc(T_RAS_NS, CLK_NS);
  localparam int CSR_CYC      = ns_to_cyc(T_CSR_NS, CLK_NS);
  localparam int CHR_CYC      = ns_to_cyc(T_CHR_NS, CLK_NS);
  localparam int HOLD_CYC     = max_of(1, RAS_CYC - CHR_CYC);
  localparam int PW           = $clog2(PAUSE_CYC + 1);
  localparam int IW           = $clog2(INIT_CYCLES + 1);
  localparam int OW           = $clog2(MAX_OWED + 1);

  phase_t        phase;
  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] init_left;
  logic [OW-1:0] owed;
  logic          tick, fin, go, run, seq_busy;

  assign run = (phase == PH_RUN);

  always_comb begin
    unique case (phase)
      PH_INIT: go = int'(init_left) > int'(fin);
      PH_RUN:  go = bus_gnt && (int'(owed) > int'(fin));
      default: go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_PAUSE;
      pause_cnt <= PW'(PAUSE_CYC - 1);
      init_left <= IW'(INIT_CYCLES);
    end else begin
      unique case (phase)
        PH_PAUSE: begin
          if (pause_cnt == '0) phase <= PH_INIT;
          else                 pause_cnt <= pause_cnt - 1'b1;
        end
        PH_INIT: begin
          if (fin) init_left <= init_left - 1'b1;
          if ((init_left == '0) && !seq_busy) phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

  refr_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (run),
    .tick (tick)
  );

  refr_owed_ctr #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .fin  (fin && run),
    .owed (owed)
  );

  refr_cbr_seq #(
    .RP_CYC   (RP_CYC),
    .CSR_CYC  (CSR_CYC),
    .CHR_CYC  (CHR_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk   (clk),
    .rst   (rst),
    .go    (go),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .drive (seq_busy),
    .fin   (fin)
  );

  assign strobe_drive = seq_busy;
  assign init_done    = run;
  assign bus_req      = run && (owed != '0);
  assign req_urgent   = run && (owed == OW'(MAX_OWED));
  assign we_n         = 1'b1;

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAUSE) |-> !seq_busy); // R2

  AST_GNT_AT_START: assert property (@(posedge clk) disable iff (rst)
    (run && $rose(seq_busy)) |-> $past(bus_gnt)); // R10

  AST_URGENT_IMPLIES_REQ: assert property (@(posedge clk) disable iff (rst)
    req_urgent |-> (bus_req && !$past(rst) && $past(init_done))); // R9

endmodule

// File: tb/sim_refr_sched.sv
module sim_refr_sched;
  localparam int INTERVAL = 200;
  localparam int PAUSE    = 200;
  localparam int RP       = 2;
  localparam int RASC     = 4;
  localparam int CSR      = 1;
  localparam int CHR      = 2;
  localparam int NINIT    = 8;
  localparam int MAXO     = 8;

  localparam int NV = 5;
  localparam int VEC_K [NV] = '{1, 3, 7, 8, 11};
  localparam int VEC_N [NV] = '{1, 3, 7, 8, 8};
  localparam int VEC_U [NV] = '{0, 0, 0, 1, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gnt = 1'b0;
  logic req, urg, idone, drv, ras_n, cas_n, we_n;

  always #2.5 clk = ~clk;

  refr_sched #(
    .CLK_NS(5), .ROWS(100), .WINDOW_NS(100_000), .WINDOW_LP_NS(400_000),
    .PAUSE_NS(1000), .INIT_CYCLES(NINIT), .MAX_OWED(MAXO),
    .T_RP_NS(10), .T_RAS_NS(20), .T_CSR_NS(5), .T_CHR_NS(10)
  ) u0 (
    .clk(clk), .rst(rst), .bus_gnt(gnt), .bus_req(req), .req_urgent(urg),
    .init_done(idone), .strobe_drive(drv), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // protocol monitor
  int cbr_cnt = 0;
  int csr_v = 0, chr_v = 0, ras_v = 0, rp_v = 0, we_v = 0, idle_v = 0, prereq_v = 0;
  int ras_hi = 100, ras_lo = 0, cas_lo = 0;
  logic p_ras = 1'b1, p_cas = 1'b1;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_cas && !cas_n && ras_n) begin
        cbr_cnt++;
        if (ras_hi < RP) rp_v++;
      end
      if (p_ras && !ras_n) begin
        if (cas_lo < CSR) csr_v++;
        if (we_n !== 1'b1) we_v++;
      end
      if (!p_cas && cas_n && !ras_n && ras_lo < CHR) chr_v++;
      if (!p_ras && ras_n && ras_lo < RASC) ras_v++;
      if (!drv && (!ras_n || !cas_n)) idle_v++;
      if (!idone && req) prereq_v++;
      if (we_n !== 1'b1) we_v++;
      ras_hi = ras_n  ? ras_hi + 1 : 0;
      ras_lo = !ras_n ? ras_lo + 1 : 0;
      cas_lo = !cas_n ? cas_lo + 1 : 0;
      p_ras  = ras_n;
      p_cas  = cas_n;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  task automatic wait_drained(input string tag);
    int n = 0;
    while ((req || drv) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 2000, tag, n, 2000);
  endtask

  initial begin
    int idx, base, n;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n, "R1 strobes", {ras_n, cas_n, we_n}, 7);
    chk(!req && !urg && !idone && !drv, "R1 flags", {req, urg, idone, drv}, 0);
    rst = 1'b0;
    idx = 0;
    while (!drv && idx < 1000) begin
      @(negedge clk);
      idx++;
    end
    // R2 pause before first drive
    chk(idx >= PAUSE && idx <= PAUSE + 2, "R2 pause", idx, PAUSE + 1);
    n = 0;
    while (!idone && n < 2000) begin
      @(negedge clk);
      n++;
    end
    // R3 init burst without grant
    chk(cbr_cnt == NINIT, "R3 init cycles", cbr_cnt, NINIT);
    chk(prereq_v == 0, "R3 req before init", prereq_v, 0);
    chk(!drv, "R3 done after precharge", drv, 0);
    // R7 first slot
    n = 0;
    while (!req && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == INTERVAL, "R7 interval", n, INTERVAL);

    // vector table: k slots owed, then grant
    for (int i = 0; i < NV; i++) begin
      n = 0;
      while (!req && n < 1000) begin
        @(negedge clk);
        n++;
      end
      repeat ((VEC_K[i] - 1) * INTERVAL + INTERVAL / 2) @(negedge clk);
      chk(req, "R7 req held while owed", req, 1);
      chk(urg == VEC_U[i][0], "R9 urgent", urg, VEC_U[i]);
      base = cbr_cnt;
      gnt  = 1'b1;
      wait_drained("R8 drain timeout");
      gnt = 1'b0;
      chk(cbr_cnt - base == VEC_N[i], "R8 drained count", cbr_cnt - base, VEC_N[i]);
      chk(!urg, "R9 urgent cleared", urg, 0);
    end

    // R10 grant withdrawn mid-cycle
    n = 0;
    while (!req && n < 1000) begin
      @(negedge clk);
      n++;
    end
    repeat (2 * INTERVAL + INTERVAL / 2) @(negedge clk);
    base = cbr_cnt;
    gnt  = 1'b1;
    n = 0;
    while (!drv && n < 100) begin
      @(negedge clk);
      n++;
    end
    gnt = 1'b0;
    n = 0;
    while (drv && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(cbr_cnt - base == 1, "R10 one cycle completes", cbr_cnt - base, 1);
    chk(req, "R10 rest still owed", req, 1);
    base = cbr_cnt;
    gnt  = 1'b1;
    wait_drained("R10 drain timeout");
    gnt = 1'b0;
    chk(cbr_cnt - base == 2, "R10 remainder", cbr_cnt - base, 2);

    // strobe protocol over whole run
    chk(csr_v == 0, "R4 CAS setup", csr_v, 0);
    chk(chr_v == 0, "R4 CAS hold", chr_v, 0);
    chk(ras_v == 0, "R5 RAS low width", ras_v, 0);
    chk(rp_v == 0, "R5 RAS precharge", rp_v, 0);
    chk(we_v == 0, "R6 WE high", we_v, 0);
    chk(idle_v == 0, "R11 idle strobes", idle_v, 0);
    finish_run();
  end

endmodule